// File: doc/BRIEF.md
# Poisoned-Packet Error Reporting Unit

This block sits in the transaction layer of a PCI Express endpoint and does the reporting work that follows the arrival of a poisoned packet. An upstream parser raises a one-cycle detect strobe, says whether the packet was a completion to a request this endpoint issued, and presents the 128-bit packet header. From that single event the block sets sticky status bits in several software-visible registers. It decides whether a fatal or a non-fatal error message should go to the root complex, and asks for it. It raises masked interrupt status bits and captures the header into two error logs.

Software reaches the block through a simple word-indexed register port. Control bits are read/write. Status bits are cleared by writing 1 to them. Log words are read-only. Message formation, packet parsing and the link itself belong to neighbouring blocks. The block only issues a one-cycle message request with a fatal/non-fatal qualifier.

Top module: `poison_err_report`

## Requirements
- R1: After reset, msg_req, msg_fatal and irq are 0. Every register at indices 0, 1, 2, 5, 7, 9..12 and 13 reads 0.
- R2: A detect strobe causes a one-cycle msg_req pulse in the next cycle when it is enabled. The pulse is enabled when register 4 bit 12 is 1 and register 1 bit 2 is set (msg_fatal=1), or when register 4 bit 12 is 0 and register 1 bit 1 is set (msg_fatal=0). It is also enabled whenever register 0 bit 8 is set, with msg_fatal still following register 4 bit 12. Otherwise no pulse is issued.
- R3: When a message is requested, register 1 bit 18 (fatal sent) or bit 17 (non-fatal sent) is set to match msg_fatal. Neither bit is set when no message goes out.
- R4: Every detect sets register 2 bit 12 and register 5 bit 12, whatever the mask settings.
- R5: Every detect sets register 0 bit 18 (parity detected). A requested message also sets register 0 bit 16 (system error signalled). A detect flagged as a completion also sets register 0 bit 17 (master data parity).
- R6: Register 7 collects interrupt status at fixed positions: bit 8 interface error on any detect, bit 4 uncorrectable message sent, bit 0 parity detected on any detect, and bit 1 master data parity for completions. Each bit is set only while its mask in register 8 is clear: bit 8 masks bit 8, bit 4 masks bit 4, and bit 0 masks both bits 0 and 1.
- R7: irq is the OR of the register 7 bits whose masks in register 8 are currently clear. Masking after the fact drops irq without clearing status.
- R8: Registers 9..12 return header words 0..3, with word k being header bits 32k+31..32k. The header is captured on a detect only while register 3 bit 12 is 0 and no earlier header is held. It is held until software writes 1 to register 2 bit 12.
- R9: Register 13 returns header bits 31..0, captured on a detect only while register 6 bit 12 is 0 and no earlier capture is held. It is released by writing 1 to register 5 bit 12, independently of the header log.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A detect in the same cycle as a clear leaves the bit set.
- R11: Control bits read back only at their positions: register 0 bit 8, register 1 bits 2 and 1, registers 3, 4 and 6 bit 12, and register 8 bits 8, 4 and 0. All other bits of those registers read 0 unless they are status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poison_det | input | 1 | One-cycle strobe: a poisoned packet was received |
| poison_cpl | input | 1 | The poisoned packet completes a request issued by this device |
| poison_hdr | input | HDR_W | Header of the poisoned packet, valid with the strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| msg_req | output | 1 | One-cycle error message request |
| msg_fatal | output | 1 | Qualifier of msg_req: 1 fatal, 0 non-fatal |
| irq | output | 1 | Interrupt, OR of unmasked interrupt status bits |

## Verification
Every effect of a detect strobe is registered once. msg_req, msg_fatal, all status bits, both logs and irq therefore change at the first rising edge that samples the strobe, and are due one cycle after it. The bench raises the strobe on a falling edge and checks the message at the next falling edge. It confirms the pulse has ended one falling edge later, then reads the registers. Reads are combinational, so each read samples 1 ns after the address settles and away from any edge. Writes take effect at the edge after they are driven, and their results are read back only after that edge.

// File: rtl/poison_err_pkg.sv
package poison_err_pkg;
    // Register word indices
    localparam int A_CMD      = 0;
    localparam int A_DEV      = 1;
    localparam int A_UNC_STS  = 2;
    localparam int A_UNC_MSK  = 3;
    localparam int A_UNC_SEV  = 4;
    localparam int A_IF_STS   = 5;
    localparam int A_IF_MSK   = 6;
    localparam int A_INT_STS  = 7;
    localparam int A_INT_MSK  = 8;
    localparam int A_HDR_BASE = 9;

    // Bit positions
    localparam int B_SERR_EN   = 8;
    localparam int B_FATAL_EN  = 2;
    localparam int B_NFATAL_EN = 1;
    localparam int B_POISON    = 12;
    localparam int B_SIG_SERR  = 16;
    localparam int B_MDPE      = 17;
    localparam int B_DPE       = 18;
    localparam int B_NF_SENT   = 17;
    localparam int B_F_SENT    = 18;
    localparam int B_INT_IF    = 8;
    localparam int B_INT_UNC   = 4;
    localparam int B_INT_MDPE  = 1;
    localparam int B_INT_DPE   = 0;

    // Packed interrupt vector order: {if, unc, mdpe, dpe}
    localparam int IV_DPE  = 0;
    localparam int IV_MDPE = 1;
    localparam int IV_UNC  = 2;
    localparam int IV_IF   = 3;
    // Packed mask order: {if, unc, parity}
    localparam int MV_PAR = 0;
    localparam int MV_UNC = 1;
    localparam int MV_IF  = 2;
endpackage

// File: rtl/poison_msg_sel.sv
module poison_msg_sel (
    input  logic sev_fatal,
    input  logic fatal_en,
    input  logic nfatal_en,
    input  logic serr_en,
    output logic send,
    output logic fatal
);
    logic class_en;

    always_comb begin
        class_en = sev_fatal ? fatal_en : nfatal_en;
        send     = class_en | serr_en;
        fatal    = sev_fatal;
    end
endmodule

// File: rtl/poison_int_ctl.sv
module poison_int_ctl import poison_err_pkg::*; (
    input  logic       ev_if,
    input  logic       ev_unc,
    input  logic       ev_dpe,
    input  logic       ev_mdpe,
    input  logic [2:0] mask,
    input  logic [3:0] sts,
    output logic [3:0] set_vec,
    output logic       irq
);
    logic [3:0] open_vec;

    always_comb begin
        open_vec          = '0;
        open_vec[IV_IF]   = ~mask[MV_IF];
        open_vec[IV_UNC]  = ~mask[MV_UNC];
        open_vec[IV_MDPE] = ~mask[MV_PAR];
        open_vec[IV_DPE]  = ~mask[MV_PAR];

        set_vec          = '0;
        set_vec[IV_IF]   = ev_if;
        set_vec[IV_UNC]  = ev_unc;
        set_vec[IV_MDPE] = ev_mdpe;
        set_vec[IV_DPE]  = ev_dpe;
        set_vec          = set_vec & open_vec;

        irq = |(sts & open_vec);
    end
endmodule

// File: rtl/poison_log_cap.sv
module poison_log_cap #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         release_log,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } log_t;

    log_t log_q, log_d;
    logic held;

    always_comb begin
        log_d = log_q;
        held  = log_q.full & ~release_log;
        if (capture && !held) begin
            log_d.full = 1'b1;
            log_d.data = din;
        end else if (release_log) begin
            log_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign dout = log_q.data;

    // R8 / R9: a held capture is never overwritten
    p_log_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (log_q.full && !release_log) |=> $stable(log_q.data));
endmodule

// File: rtl/poison_err_report.sv
module poison_err_report import poison_err_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int HDR_W  = 128,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poison_det,
    input  logic              poison_cpl,
    input  logic [HDR_W-1:0]  poison_hdr,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              msg_req,
    output logic              msg_fatal,
    output logic              irq
);
    localparam int HDR_WORDS = HDR_W / DATA_W;
    localparam int A_IF_LOG  = A_HDR_BASE + HDR_WORDS;

    typedef struct packed {
        logic       serr_en;
        logic       fatal_en;
        logic       nfatal_en;
        logic       unc_mask;
        logic       unc_sev;
        logic       if_mask;
        logic [2:0] int_mask;
        logic       sig_serr;
        logic       mdpe;
        logic       dpe;
        logic       f_sent;
        logic       nf_sent;
        logic       unc_poison;
        logic       if_poison;
        logic [3:0] int_sts;
        logic       msg_req;
        logic       msg_fatal;
    } state_t;

    state_t st_q, st_d;

    logic send_w, fatal_w;
    logic [3:0] int_set;
    logic irq_w;
    logic hit_cmd, hit_dev, hit_unc_sts, hit_unc_msk, hit_unc_sev;
    logic hit_if_sts, hit_if_msk, hit_int_sts, hit_int_msk;
    logic clr_unc, clr_if;
    logic [HDR_W-1:0]  hdr_log;
    logic [DATA_W-1:0] if_log;

    always_comb begin
        hit_cmd     = reg_we && (reg_addr == ADDR_W'(A_CMD));
        hit_dev     = reg_we && (reg_addr == ADDR_W'(A_DEV));
        hit_unc_sts = reg_we && (reg_addr == ADDR_W'(A_UNC_STS));
        hit_unc_msk = reg_we && (reg_addr == ADDR_W'(A_UNC_MSK));
        hit_unc_sev = reg_we && (reg_addr == ADDR_W'(A_UNC_SEV));
        hit_if_sts  = reg_we && (reg_addr == ADDR_W'(A_IF_STS));
        hit_if_msk  = reg_we && (reg_addr == ADDR_W'(A_IF_MSK));
        hit_int_sts = reg_we && (reg_addr == ADDR_W'(A_INT_STS));
        hit_int_msk = reg_we && (reg_addr == ADDR_W'(A_INT_MSK));
        clr_unc     = hit_unc_sts && reg_wdata[B_POISON];
        clr_if      = hit_if_sts && reg_wdata[B_POISON];
    end

    poison_msg_sel u_msg_sel (
        .sev_fatal (st_q.unc_sev),
        .fatal_en  (st_q.fatal_en),
        .nfatal_en (st_q.nfatal_en),
        .serr_en   (st_q.serr_en),
        .send      (send_w),
        .fatal     (fatal_w)
    );

    poison_int_ctl u_int_ctl (
        .ev_if   (poison_det),
        .ev_unc  (poison_det & send_w),
        .ev_dpe  (poison_det),
        .ev_mdpe (poison_det & poison_cpl),
        .mask    (st_q.int_mask),
        .sts     (st_q.int_sts),
        .set_vec (int_set),
        .irq     (irq_w)
    );

    poison_log_cap #(.W(HDR_W)) u_hdr_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (poison_det & ~st_q.unc_mask),
        .release_log (clr_unc),
        .din         (poison_hdr),
        .dout        (hdr_log)
    );

    poison_log_cap #(.W(DATA_W)) u_if_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (poison_det & ~st_q.if_mask),
        .release_log (clr_if),
        .din         (poison_hdr[DATA_W-1:0]),
        .dout        (if_log)
    );

    always_comb begin
        st_d           = st_q;
        st_d.msg_req   = 1'b0;
        st_d.msg_fatal = 1'b0;

        // control writes and write-1-to-clear
        if (hit_cmd) begin
            st_d.serr_en = reg_wdata[B_SERR_EN];
            if (reg_wdata[B_SIG_SERR]) st_d.sig_serr = 1'b0;
            if (reg_wdata[B_MDPE])     st_d.mdpe     = 1'b0;
            if (reg_wdata[B_DPE])      st_d.dpe      = 1'b0;
        end
        if (hit_dev) begin
            st_d.fatal_en  = reg_wdata[B_FATAL_EN];
            st_d.nfatal_en = reg_wdata[B_NFATAL_EN];
            if (reg_wdata[B_F_SENT])  st_d.f_sent  = 1'b0;
            if (reg_wdata[B_NF_SENT]) st_d.nf_sent = 1'b0;
        end
        if (clr_unc)     st_d.unc_poison = 1'b0;
        if (hit_unc_msk) st_d.unc_mask   = reg_wdata[B_POISON];
        if (hit_unc_sev) st_d.unc_sev    = reg_wdata[B_POISON];
        if (clr_if)      st_d.if_poison  = 1'b0;
        if (hit_if_msk)  st_d.if_mask    = reg_wdata[B_POISON];
        if (hit_int_sts) begin
            if (reg_wdata[B_INT_IF])   st_d.int_sts[IV_IF]   = 1'b0;
            if (reg_wdata[B_INT_UNC])  st_d.int_sts[IV_UNC]  = 1'b0;
            if (reg_wdata[B_INT_MDPE]) st_d.int_sts[IV_MDPE] = 1'b0;
            if (reg_wdata[B_INT_DPE])  st_d.int_sts[IV_DPE]  = 1'b0;
        end
        if (hit_int_msk) begin
            st_d.int_mask[MV_IF]  = reg_wdata[B_INT_IF];
            st_d.int_mask[MV_UNC] = reg_wdata[B_INT_UNC];
            st_d.int_mask[MV_PAR] = reg_wdata[B_INT_DPE];
        end

        // event sets win over clears
        if (poison_det) begin
            st_d.unc_poison = 1'b1;
            st_d.if_poison  = 1'b1;
            st_d.dpe        = 1'b1;
            if (poison_cpl) st_d.mdpe = 1'b1;
            if (send_w) begin
                st_d.msg_req   = 1'b1;
                st_d.msg_fatal = fatal_w;
                st_d.sig_serr  = 1'b1;
                if (fatal_w) st_d.f_sent  = 1'b1;
                else         st_d.nf_sent = 1'b1;
            end
        end
        st_d.int_sts = st_d.int_sts | int_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            A_CMD: begin
                reg_rdata[B_SERR_EN]  = st_q.serr_en;
                reg_rdata[B_SIG_SERR] = st_q.sig_serr;
                reg_rdata[B_MDPE]     = st_q.mdpe;
                reg_rdata[B_DPE]      = st_q.dpe;
            end
            A_DEV: begin
                reg_rdata[B_FATAL_EN]  = st_q.fatal_en;
                reg_rdata[B_NFATAL_EN] = st_q.nfatal_en;
                reg_rdata[B_F_SENT]    = st_q.f_sent;
                reg_rdata[B_NF_SENT]   = st_q.nf_sent;
            end
            A_UNC_STS: reg_rdata[B_POISON] = st_q.unc_poison;
            A_UNC_MSK: reg_rdata[B_POISON] = st_q.unc_mask;
            A_UNC_SEV: reg_rdata[B_POISON] = st_q.unc_sev;
            A_IF_STS:  reg_rdata[B_POISON] = st_q.if_poison;
            A_IF_MSK:  reg_rdata[B_POISON] = st_q.if_mask;
            A_INT_STS: begin
                reg_rdata[B_INT_IF]   = st_q.int_sts[IV_IF];
                reg_rdata[B_INT_UNC]  = st_q.int_sts[IV_UNC];
                reg_rdata[B_INT_MDPE] = st_q.int_sts[IV_MDPE];
                reg_rdata[B_INT_DPE]  = st_q.int_sts[IV_DPE];
            end
            A_INT_MSK: begin
                reg_rdata[B_INT_IF]  = st_q.int_mask[MV_IF];
                reg_rdata[B_INT_UNC] = st_q.int_mask[MV_UNC];
                reg_rdata[B_INT_DPE] = st_q.int_mask[MV_PAR];
            end
            A_IF_LOG: reg_rdata = if_log;
            default: begin
                for (int k = 0; k < HDR_WORDS; k++) begin
                    if (int'(reg_addr) == A_HDR_BASE + k)
                        reg_rdata = hdr_log[k*DATA_W +: DATA_W];
                end
            end
        endcase
    end

    assign msg_req   = st_q.msg_req;
    assign msg_fatal = st_q.msg_fatal;
    assign irq       = irq_w;

    // R2: a message request only follows a detect strobe
    p_msg_follows_det_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> $past(poison_det));
    // R3: the matching sent-status bit is present with the request
    p_sent_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> (msg_fatal ? st_q.f_sent : st_q.nf_sent));
    // R4: both poison status bits are set after any detect
    p_poison_sts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(poison_det) |-> (st_q.unc_poison && st_q.if_poison));
    // R5: parity detected is set after any detect
    p_dpe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(poison_det) |-> st_q.dpe);
    // R7: no interrupt without some status bit
    p_irq_needs_sts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.int_sts != 4'b0));
    // R10: a status bit stays set until written with 1
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.unc_poison && !clr_unc) |=> st_q.unc_poison);
endmodule

// File: tb/poison_err_report_tb_top.sv
`timescale 1ns/1ps
module poison_err_report_tb_top;
    localparam int DATA_W = 32;
    localparam int HDR_W  = 128;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              poison_det = 1'b0;
    logic              poison_cpl = 1'b0;
    logic [HDR_W-1:0]  poison_hdr = '0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              msg_req, msg_fatal, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    poison_err_report #(.DATA_W(DATA_W), .HDR_W(HDR_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .poison_det(poison_det), .poison_cpl(poison_cpl),
        .poison_hdr(poison_hdr), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_req(msg_req),
        .msg_fatal(msg_fatal), .irq(irq)
    );

    // vector fields: {sev, fatal_en, nfatal_en, serr_en, cpl, exp_msg, exp_fatal}
    localparam logic [6:0] VEC [8] = '{
        7'b1100011, 7'b1010000, 7'b0010110, 7'b0100000,
        7'b0001010, 7'b1001111, 7'b0000100, 7'b1111011
    };

    function automatic logic [HDR_W-1:0] mk_hdr(input int s);
        return {32'hC0DE0000 + s, 32'h00001000 + s, 32'h00002000 + s, 32'h00003000 + s};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
    endtask

    task automatic clear_all(input logic serr, input logic fen, input logic nfen);
        wr(0, 32'hFFFF_0000 | (32'(serr) << 8));
        wr(1, 32'hFFFF_0000 | (32'(fen) << 2) | (32'(nfen) << 1));
        wr(2, 32'hFFFF_FFFF);
        wr(5, 32'hFFFF_FFFF);
        wr(7, 32'hFFFF_FFFF);
    endtask

    // pulse detect; returns msg outputs seen one cycle later
    task automatic pulse(input logic [HDR_W-1:0] h, input logic cpl, output logic m, output logic f);
        @(negedge clk);
        poison_det = 1'b1; poison_cpl = cpl; poison_hdr = h;
        @(negedge clk);
        m = msg_req; f = msg_fatal;
        poison_det = 1'b0; poison_cpl = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic m, f;
        logic [HDR_W-1:0] last_hdr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1", "msg_req", 32'(msg_req), 0);
        check("R1", "irq", 32'(irq), 0);
        foreach (VEC[i]) begin end
        for (int a = 0; a < 14; a++) begin
            if (a == 3 || a == 4 || a == 6 || a == 8) continue;
            rd(a, r);
            check("R1", $sformatf("reg %0d", a), r, 0);
        end

        // table walk: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            logic [6:0] v;
            logic sev, fen, nfen, serr, cpl, em, ef;
            v = VEC[i];
            {sev, fen, nfen, serr, cpl, em, ef} = v;
            clear_all(serr, fen, nfen);
            wr(4, 32'(sev) << 12);
            pulse(mk_hdr(i), cpl, m, f);
            check("R2", $sformatf("vec %0d msg_req", i), 32'(m), 32'(em));
            check("R2", $sformatf("vec %0d msg_fatal", i), 32'(f), em ? 32'(ef) : 0);
            @(negedge clk);
            check("R2", $sformatf("vec %0d single pulse", i), 32'(msg_req), 0);
            rd(1, r);
            check("R3", $sformatf("vec %0d dev", i), r,
                  (32'(em & ef) << 18) | (32'(em & ~ef) << 17) | (32'(fen) << 2) | (32'(nfen) << 1));
            rd(0, r);
            check("R5", $sformatf("vec %0d cmd", i), r,
                  (32'(1) << 18) | (32'(cpl) << 17) | (32'(em) << 16) | (32'(serr) << 8));
            rd(7, r);
            check("R6", $sformatf("vec %0d int_sts", i), r,
                  32'h101 | (32'(em) << 4) | (32'(cpl) << 1));
            check("R7", $sformatf("vec %0d irq", i), 32'(irq), 1);
            rd(9, r);
            check("R8", $sformatf("vec %0d hdr word0", i), r, 32'h3000 + i);
            rd(13, r);
            check("R9", $sformatf("vec %0d if log", i), r, 32'h3000 + i);
        end
        last_hdr = mk_hdr(7);

        // R4: masks block logs and interrupts, not status
        clear_all(1'b0, 1'b0, 1'b0);
        wr(3, 32'h0000_1000);
        wr(6, 32'h0000_1000);
        wr(8, 32'h0000_0111);
        pulse(mk_hdr(20), 1'b1, m, f);
        check("R2", "no enable no msg", 32'(m), 0);
        rd(2, r); check("R4", "unc sts under mask", r, 32'h1000);
        rd(5, r); check("R4", "if sts under mask", r, 32'h1000);
        rd(7, r); check("R6", "int sts masked", r, 0);
        check("R7", "irq masked", 32'(irq), 0);
        rd(12, r); check("R8", "hdr not captured when masked", r, last_hdr[127:96]);
        rd(13, r); check("R9", "if log not captured when masked", r, last_hdr[31:0]);

        // R11: control readback
        wr(3, 32'hFFFF_FFFF);
        rd(3, r); check("R11", "unc mask readback", r, 32'h1000);
        wr(8, 32'hFFFF_FFFF);
        rd(8, r); check("R11", "int mask readback", r, 32'h111);

        // R8/R9: hold first capture, independent release
        wr(3, 0); wr(6, 0); wr(8, 0);
        clear_all(1'b0, 1'b0, 1'b0);
        pulse(mk_hdr(30), 1'b0, m, f);
        pulse(mk_hdr(31), 1'b0, m, f);
        rd(12, r); check("R8", "hdr held word3", r, 32'hC0DE0000 + 30);
        rd(13, r); check("R9", "if log held", r, 32'h3000 + 30);
        wr(2, 32'h1000);
        pulse(mk_hdr(32), 1'b0, m, f);
        rd(10, r); check("R8", "hdr recaptured word1", r, 32'h2000 + 32);
        rd(13, r); check("R9", "if log still held", r, 32'h3000 + 30);

        // R7: mask after the fact drops irq, status stays
        check("R7", "irq before mask", 32'(irq), 1);
        wr(8, 32'h111);
        check("R7", "irq after mask", 32'(irq), 0);
        rd(7, r); check("R7", "status kept under mask", r, 32'h101);
        wr(8, 0);

        // R10: write 0 keeps, write 1 clears, set wins
        wr(2, 32'h0);
        rd(2, r); check("R10", "write 0 keeps", r, 32'h1000);
        wr(2, 32'h1000);
        rd(2, r); check("R10", "write 1 clears", r, 0);
        @(negedge clk);
        poison_det = 1'b1; reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h1000;
        @(negedge clk);
        poison_det = 1'b0; reg_we = 1'b0;
        rd(2, r); check("R10", "set wins over clear", r, 32'h1000);

        finish_run();
    end
endmodule